// File: doc/BRIEF.md
# Debounced Matrix Keypad Row Scanner

This block walks a 4-row matrix keypad one row at a time. It drives a single row line high and watches the column lines, which read high when a key connects them to the driven row and are pulled low otherwise. The column lines are registered once against the system clock before any decision is made. All state changes happen on a slow enable strobe, produced by an internal divider that fires once every `DIV_COUNT` system cycles (100000 at 48 MHz gives 480 Hz).

Each row has three states: scan, candidate and hold. A press counts only when exactly one column is high, so two or more keys are treated as no press. A press seen while scanning a row keeps that row driven and starts a debounce count. If the press stays valid until the count reaches `DB_TICKS` enable ticks (24 ticks, or 50 ms at 480 Hz), the key is accepted. At that point a one-cycle confirm pulse is emitted and the FSM holds the row until the key is let go. Scanning then resumes at the next row.

The states, in encoding order, are R0_SCAN, R0_CAND, R0_HOLD, R1_SCAN, R1_CAND, R1_HOLD, R2_SCAN, R2_CAND, R2_HOLD, R3_SCAN, R3_CAND and R3_HOLD. Any other encoding returns to R0_SCAN. The transitions are:

- scan→cand on a valid press.
- scan→next scan with no valid press.
- cand→cand while the press is valid and the count is below the threshold.
- cand→hold when the count has reached the threshold.
- cand→next scan when the press is lost.
- hold→hold while the press is valid.
- hold→next scan on release.

"Next" wraps from row 3 to row 0. A downstream decoder combines the held row with the synchronized columns to form a key code.

Top module: `kpscan_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters R0_SCAN, clears the debounce count and clears the divider. After reset, `row_sel` = 4'b0001 and `confirm` = 0.
- R2: The FSM changes state only on the enable strobe. That strobe is true in the last cycle of every `DIV_COUNT`-cycle period counted from reset release, so the first state change falls on the `DIV_COUNT`-th clock edge after release.
- R3: In a scan state with no valid press, each enable tick moves to the next row's scan state. `row_sel` follows 0001→0010→0100→1000→0001.
- R4: A valid press means exactly one column bit is high. All-zero patterns and patterns with two or more bits high are treated as no press, both in scan states and in hold states.
- R5: In a scan state, a valid press at the tick moves to that row's candidate state, and `row_sel` keeps the same row.
- R6: In a candidate state, a tick without a valid press moves to the next row's scan state, wrapping from row 3 to row 0, and no confirm is emitted.
- R7: In a candidate state, each tick with a valid press raises the count by one until it reaches `DB_TICKS`. The key is accepted on the first tick at which the count already equals `DB_TICKS`, which is tick `DB_TICKS`+1 after candidate entry. On that tick `confirm` is high and the FSM enters hold.
- R8: `confirm` is high for exactly one system-clock cycle per accepted press, and it is never high again while that key stays held.
- R9: A hold state keeps its row while the press stays valid. On release, meaning any pattern that is not a valid press, it moves to the next row's scan state, and from row 3 that is row 0.
- R10: The debounce count is zero whenever the FSM is in a scan or hold state. Every candidate entry therefore needs the full `DB_TICKS`+1 ticks, and the count never exceeds `DB_TICKS`.
- R11: The columns reach the FSM through one synchronizing register. A column change made less than one clock before an enable tick is not seen at that tick.
- R12: `row_sel` is always one-hot, and `row_drv` always equals `row_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| col_in | input | COLS | Raw column lines, high when pressed |
| row_sel | output | 4 | One-hot row currently scanned or held |
| row_drv | output | 4 | Active-high row drive lines, equal to `row_sel` |
| confirm | output | 1 | One-cycle pulse when a key is accepted |

## Verification
The bench builds the block with `DIV_COUNT` = 4 and `DB_TICKS` = 3. With these values a whole row rotation, a full debounce and several hold ticks each take only tens of cycles. The bench can then place a column change exactly one cycle before an enable tick to expose the synchronizer latency. It can also bounce a key after two counted ticks and show that the next candidate entry starts its count again from zero. A reset in the middle of a candidate state is included to show that the divider phase restarts.

// File: rtl/kpscan_pkg.sv
package kpscan_pkg;

    localparam int KP_ROWS = 4;

    typedef enum logic [3:0] {
        KP_R0_SCAN = 4'd0,
        KP_R0_CAND = 4'd1,
        KP_R0_HOLD = 4'd2,
        KP_R1_SCAN = 4'd3,
        KP_R1_CAND = 4'd4,
        KP_R1_HOLD = 4'd5,
        KP_R2_SCAN = 4'd6,
        KP_R2_CAND = 4'd7,
        KP_R2_HOLD = 4'd8,
        KP_R3_SCAN = 4'd9,
        KP_R3_CAND = 4'd10,
        KP_R3_HOLD = 4'd11
    } kp_state_t;

    typedef enum logic [1:0] {
        PH_SCAN = 2'd0,
        PH_CAND = 2'd1,
        PH_HOLD = 2'd2
    } kp_phase_t;

    function automatic kp_phase_t st_phase(input kp_state_t s);
        kp_phase_t p;
        unique case (s)
            KP_R0_SCAN, KP_R1_SCAN, KP_R2_SCAN, KP_R3_SCAN: p = PH_SCAN;
            KP_R0_CAND, KP_R1_CAND, KP_R2_CAND, KP_R3_CAND: p = PH_CAND;
            KP_R0_HOLD, KP_R1_HOLD, KP_R2_HOLD, KP_R3_HOLD: p = PH_HOLD;
            default:                                        p = PH_SCAN;
        endcase
        return p;
    endfunction

    function automatic logic [KP_ROWS-1:0] st_row(input kp_state_t s);
        logic [KP_ROWS-1:0] r;
        unique case (s)
            KP_R0_SCAN, KP_R0_CAND, KP_R0_HOLD: r = 4'b0001;
            KP_R1_SCAN, KP_R1_CAND, KP_R1_HOLD: r = 4'b0010;
            KP_R2_SCAN, KP_R2_CAND, KP_R2_HOLD: r = 4'b0100;
            KP_R3_SCAN, KP_R3_CAND, KP_R3_HOLD: r = 4'b1000;
            default:                            r = 4'b0001;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/kpscan_colsync.sv
module kpscan_colsync #(
    parameter int COLS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] col_in,
    output logic [COLS-1:0] col_sync
);

    always_ff @(posedge clk) begin
        if (!rst_n) col_sync <= '0;
        else        col_sync <= col_in;
    end

    // R11: the FSM sees the column value of the previous cycle
    a_r11_one_cycle_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (col_sync == $past(col_in)));

endmodule

// File: rtl/kpscan_tick.sv
module kpscan_tick #(
    parameter int DIV_COUNT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int DW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV_COUNT - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + DW'(1);
    end

    always_comb tick = (cnt == LAST);

    // R2: divider never leaves its period
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R2: strobe is a single-cycle pulse when the period exceeds one cycle
    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (DIV_COUNT > 1)) |=> !tick);

endmodule

// File: rtl/kpscan_fsm.sv
module kpscan_fsm
    import kpscan_pkg::*;
#(
    parameter int COLS     = 4,
    parameter int DB_TICKS = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [COLS-1:0]    col_sync,
    output logic [KP_ROWS-1:0] row_sel,
    output logic               confirm
);

    localparam int CW = $clog2(DB_TICKS + 1);
    localparam logic [CW-1:0] DB_LIMIT = CW'(DB_TICKS);

    kp_state_t     state;
    kp_state_t     state_nx;
    kp_phase_t     phase;
    logic [CW-1:0] dbc;
    logic          press;
    logic          db_done;
    logic          in_scan;
    logic          in_cand;
    logic          in_hold;

    // exactly one column high
    always_comb press = (col_sync != '0) &&
                        ((col_sync & (col_sync - COLS'(1))) == '0);

    always_comb db_done = (dbc >= DB_LIMIT);

    always_comb begin
        phase   = st_phase(state);
        in_scan = (phase == PH_SCAN);
        in_cand = (phase == PH_CAND);
        in_hold = (phase == PH_HOLD);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            KP_R0_SCAN: state_nx = press ? KP_R0_CAND : KP_R1_SCAN;
            KP_R0_CAND: state_nx = !press ? KP_R1_SCAN : (db_done ? KP_R0_HOLD : KP_R0_CAND);
            KP_R0_HOLD: state_nx = press ? KP_R0_HOLD : KP_R1_SCAN;
            KP_R1_SCAN: state_nx = press ? KP_R1_CAND : KP_R2_SCAN;
            KP_R1_CAND: state_nx = !press ? KP_R2_SCAN : (db_done ? KP_R1_HOLD : KP_R1_CAND);
            KP_R1_HOLD: state_nx = press ? KP_R1_HOLD : KP_R2_SCAN;
            KP_R2_SCAN: state_nx = press ? KP_R2_CAND : KP_R3_SCAN;
            KP_R2_CAND: state_nx = !press ? KP_R3_SCAN : (db_done ? KP_R2_HOLD : KP_R2_CAND);
            KP_R2_HOLD: state_nx = press ? KP_R2_HOLD : KP_R3_SCAN;
            KP_R3_SCAN: state_nx = press ? KP_R3_CAND : KP_R0_SCAN;
            KP_R3_CAND: state_nx = !press ? KP_R0_SCAN : (db_done ? KP_R3_HOLD : KP_R3_CAND);
            KP_R3_HOLD: state_nx = press ? KP_R3_HOLD : KP_R0_SCAN;
            default:    state_nx = KP_R0_SCAN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= KP_R0_SCAN;
        else if (tick) state <= state_nx;
    end

    // debounce counter: zero outside candidate, saturating inside
    always_ff @(posedge clk) begin
        if (!rst_n)                        dbc <= '0;
        else if (!in_cand)                 dbc <= '0;
        else if (tick && press && !db_done) dbc <= dbc + CW'(1);
    end

    // outputs
    always_comb begin
        row_sel = st_row(state);
        confirm = tick && in_cand && press && db_done;
    end

    // R2: no state change without the enable strobe
    a_r2_stable_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state));

    // R5: a candidate entry keeps the same row driven
    a_r5_cand_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && in_scan && press) |=> $stable(row_sel));

    // R7: an accepted key always lands in a hold state
    a_r7_confirm_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        confirm |=> in_hold);

    // R10: each candidate entry starts counting from zero
    a_r10_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && in_scan && press) |=> (dbc == '0));

    // R10: counter saturates at the threshold
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        dbc <= DB_LIMIT);

    // R8: one pulse, then the key is held
    a_r8_single_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        confirm |=> !confirm);

endmodule

// File: rtl/kpscan_top.sv
module kpscan_top
    import kpscan_pkg::*;
#(
    parameter int COLS      = 4,
    parameter int DIV_COUNT = 100000,
    parameter int DB_TICKS  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COLS-1:0]    col_in,
    output logic [KP_ROWS-1:0] row_sel,
    output logic [KP_ROWS-1:0] row_drv,
    output logic               confirm
);

    logic [COLS-1:0] col_sync;
    logic            tick;

    kpscan_colsync #(.COLS(COLS)) u_colsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .col_in   (col_in),
        .col_sync (col_sync)
    );

    kpscan_tick #(.DIV_COUNT(DIV_COUNT)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    kpscan_fsm #(.COLS(COLS), .DB_TICKS(DB_TICKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .col_sync (col_sync),
        .row_sel  (row_sel),
        .confirm  (confirm)
    );

    always_comb row_drv = row_sel;

    // R12: exactly one row is selected at any time
    a_r12_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_sel) == 1);

endmodule

// File: tb/kpscan_top_bench.sv
module kpscan_top_bench;

    localparam int COLS = 4;
    localparam int DIV  = 4;
    localparam int TH   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [COLS-1:0] col_in = '0;
    logic [3:0]      row_sel;
    logic [3:0]      row_drv;
    logic            confirm;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int wide_pulses = 0;
    logic prev_conf = 1'b0;

    kpscan_top #(.COLS(COLS), .DIV_COUNT(DIV), .DB_TICKS(TH)) u_kpscan_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .col_in  (col_in),
        .row_sel (row_sel),
        .row_drv (row_drv),
        .confirm (confirm)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && confirm) begin
            pulses++;
            if (prev_conf) wide_pulses++;
        end
        prev_conf = rst_n && confirm;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // advance n enable periods, sample just after the tick edge
    task automatic tick_step(input int n);
        repeat (n * DIV) @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        col_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset row", row_sel, 4'b0001);
        check("R12 drive equals row", row_drv, 4'b0001);
        check("R1 confirm low", confirm, 0);
    endtask

    task automatic t_rotation();
        repeat (DIV - 1) @(posedge clk);
        #2;
        check("R2 no change before tick", row_sel, 4'b0001);
        @(posedge clk);
        #2;
        check("R2 change on tick", row_sel, 4'b0010);
        tick_step(1); check("R3 rotate row2", row_sel, 4'b0100);
        tick_step(1); check("R3 rotate row3", row_sel, 4'b1000);
        tick_step(1); check("R3 wrap row0", row_sel, 4'b0001);
        check("R12 drive follows", row_drv, 4'b0001);
    endtask

    task automatic t_multikey();
        int p0 = pulses;
        col_in = 4'b0110;
        tick_step(1); check("R4 multi ignored r1", row_sel, 4'b0010);
        tick_step(1); check("R4 multi ignored r2", row_sel, 4'b0100);
        tick_step(2); check("R4 multi ignored wrap", row_sel, 4'b0001);
        check("R4 no confirm on multi", pulses, p0);
        col_in = '0;
    endtask

    task automatic t_press_hold();
        int p0 = pulses;
        col_in = 4'b0100;
        tick_step(1);  check("R5 candidate keeps row0", row_sel, 4'b0001);
        tick_step(TH); check("R7 no early confirm", pulses, p0);
        check("R7 still row0", row_sel, 4'b0001);
        tick_step(1);  check("R7 confirm at threshold", pulses, p0 + 1);
        tick_step(5);  check("R9 hold keeps row0", row_sel, 4'b0001);
        check("R8 single confirm while held", pulses, p0 + 1);
        col_in = '0;
        tick_step(1);  check("R9 release to next row", row_sel, 4'b0010);
    endtask

    task automatic t_bounce();
        int p0 = pulses;
        col_in = 4'b0001;
        tick_step(1); check("R5 candidate row1", row_sel, 4'b0010);
        tick_step(2);
        col_in = '0;
        tick_step(1); check("R6 bounce to next row", row_sel, 4'b0100);
        check("R6 no confirm on bounce", pulses, p0);
        col_in = 4'b0001;
        tick_step(1); check("R5 candidate row2", row_sel, 4'b0100);
        tick_step(TH); check("R10 count restarts", pulses, p0);
        tick_step(1); check("R10 full window confirm", pulses, p0 + 1);
        col_in = 4'b0011;
        tick_step(1); check("R9 multi in hold releases", row_sel, 4'b1000);
        col_in = '0;
    endtask

    task automatic t_wrap();
        int p0 = pulses;
        col_in = 4'b1000;
        tick_step(1); check("R5 candidate row3", row_sel, 4'b1000);
        col_in = 4'b1100;
        tick_step(1); check("R6 multi in candidate wraps", row_sel, 4'b0001);
        col_in = '0;
        tick_step(3); check("R3 back at row3", row_sel, 4'b1000);
        col_in = 4'b0010;
        tick_step(TH + 2); check("R7 confirm on row3", pulses, p0 + 1);
        check("R9 hold row3", row_sel, 4'b1000);
        col_in = '0;
        tick_step(1); check("R9 release wraps row0", row_sel, 4'b0001);
    endtask

    task automatic t_sync();
        repeat (DIV - 1) @(posedge clk);
        #2;
        col_in = 4'b0001;
        @(posedge clk);
        #2;
        check("R11 late change unseen", row_sel, 4'b0010);
        tick_step(1); check("R11 seen next tick", row_sel, 4'b0010);
        col_in = '0;
        tick_step(1); check("R6 lose to row2", row_sel, 4'b0100);
    endtask

    task automatic t_reset_mid();
        col_in = 4'b0001;
        tick_step(1); check("R5 candidate before reset", row_sel, 4'b0100);
        do_reset();
        check("R1 reset mid candidate", row_sel, 4'b0001);
        tick_step(1); check("R1 divider restarted", row_sel, 4'b0010);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rotation();
        t_multikey();
        t_press_hold();
        t_bounce();
        t_wrap();
        t_sync();
        t_reset_mid();
        check("R8 pulse one cycle wide", wide_pulses, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule